// File: doc/BRIEF.md
# Trace Instruction Type Classifier

This block sits where retired instructions leave a RISC-V core and enter a trace encoder. Each retired instruction arrives as a pre-decoded operation class, together with its destination and source register indices and flags for interrupts, exceptions and branch outcome. From these the block produces an instruction-type code. The encoder uses that code to decide whether to emit a message, extend a branch history, or act on its call stack. The code is registered and comes out one cycle after the retire strobe.

A parameter chooses between two code widths. The 3-bit form marks only traps, trap returns, branches and generic indirect jumps. The 4-bit form also splits jumps into direct and indirect calls, function returns, co-routine swaps, and other direct or indirect jumps, so that an encoder with return-address tracking can follow the call stack. A register counts as a link register only when it is x1 or x5. A run-time enable can make direct unconditional jumps report as taken branches.

Top module: `trc_itype_classifier`

## Requirements
- R1: While `rst_n` is low, `type_valid` is 0 and `type_code` is 0.
- R2: The `op_class` encoding is:
  - 0: other instruction.
  - 1: conditional branch.
  - 2: JAL.
  - 3: JALR.
  - 4: compressed JAL.
  - 5: compressed J.
  - 6: compressed JALR.
  - 7: compressed JR.
  - 8: table jump.
  - 9: table jump-and-link.
  - 10: pop-and-return.
  - 11: trap return (MRET or SRET).
  - 12: environment call or breakpoint (ECALL, EBREAK, compressed EBREAK).
  - 13 to 15: treated as other and give code 0.
- R3: `type_valid` equals `ret_valid` from one clock earlier. `type_code` changes only on a cycle after `ret_valid` was high, and otherwise holds its value.
- R4: Traps take priority over the instruction class.
  - `trap_irq` gives code 2, whatever `trap_exc` is.
  - `trap_exc` without `trap_irq` gives code 1.
- R5: With no trap flag set, the following codes apply in both widths:
  - class 12 gives 1.
  - class 11 gives 3.
  - class 1 gives 5 when `br_taken` is 1 and 4 when it is 0.
  - class 0 gives 0.
- R6: A register index counts as a link register only when it equals exactly 1 or 5 over its full width.
- R7: In 4-bit mode, direct forms map as follows:
  - JAL with a link `rd` gives 9; JAL with any other `rd` gives 15.
  - Compressed JAL gives 9.
  - Compressed J gives 15.
  - Table jump gives 15.
  - Table jump-and-link gives 9.
- R8: In 4-bit mode, JALR maps as follows, and code 6 never appears in 4-bit mode:
  - link `rd` with non-link `rs1` gives 8.
  - link `rd` and link `rs1` that differ give 12.
  - link `rd` and link `rs1` that are the same register give 8.
  - non-link `rd` with link `rs1` gives 13.
  - every other case gives 14.
- R9: In 4-bit mode, compressed JALR gives 12 when `rs1` is 5 and 8 otherwise. Compressed JR gives 13 for a link `rs1` and 14 otherwise. Pop-and-return gives 13.
- R10: In 3-bit mode, every direct jump or call (classes 2, 4, 5, 8, 9) gives 0. Classes 3, 6, 7 and 10 give 6.
- R11: When `all_jumps_en` is 1, direct unconditional jumps report code 5 instead of the value they would otherwise give.
  - In 4-bit mode this applies to those that would give 15; direct calls keep 9.
  - In 3-bit mode it applies to all direct jumps and calls.
  - Indirect forms are unaffected.

Parameters: `WIDE_CODE` (1 selects the 4-bit code, 0 the 3-bit code) and `REG_W` (register index width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | An instruction retired this cycle |
| op_class | input | 4 | Pre-decoded operation class (R2) |
| rd_idx | input | REG_W | Destination register index |
| rs1_idx | input | REG_W | First source register index |
| trap_exc | input | 1 | Exception trap follows this instruction |
| trap_irq | input | 1 | Interrupt trap follows this instruction |
| br_taken | input | 1 | Conditional branch outcome |
| all_jumps_en | input | 1 | Report direct unconditional jumps as taken branches |
| type_valid | output | 1 | Registered retire strobe |
| type_code | output | 3 or 4 (`WIDE_CODE`) | Registered instruction-type code |

## Verification
The assertions assume that the side inputs are meaningful only while `ret_valid` is high. They also assume that `rd_idx` and `rs1_idx` hold indices the decoder really produced for the class given. The bench drives every input at the falling edge and raises `ret_valid` only on cycles that carry a complete, consistent vector. It drops `ret_valid` only in the dedicated hold scenario.

Both widths are instantiated side by side on the same stimulus. Each directed vector therefore checks the 4-bit and the 3-bit mapping together. Register indices include x21, whose low bits match x5, to show that link detection compares the full index.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [3:0] {
      OPC_OTHER  = 4'd0,
      OPC_BRANCH = 4'd1,
      OPC_JAL    = 4'd2,
      OPC_JALR   = 4'd3,
      OPC_CJAL   = 4'd4,
      OPC_CJ     = 4'd5,
      OPC_CJALR  = 4'd6,
      OPC_CJR    = 4'd7,
      OPC_TBLJ   = 4'd8,
      OPC_TBLJAL = 4'd9,
      OPC_POPRET = 4'd10,
      OPC_XRET   = 4'd11,
      OPC_ENV    = 4'd12,
      OPC_RSV13  = 4'd13,
      OPC_RSV14  = 4'd14,
      OPC_RSV15  = 4'd15
   } op_class_e;

   localparam logic [3:0] TC_NONE     = 4'd0;
   localparam logic [3:0] TC_EXC      = 4'd1;
   localparam logic [3:0] TC_IRQ      = 4'd2;
   localparam logic [3:0] TC_TRET     = 4'd3;
   localparam logic [3:0] TC_BR_NT    = 4'd4;
   localparam logic [3:0] TC_BR_TK    = 4'd5;
   localparam logic [3:0] TC_IND      = 4'd6;
   localparam logic [3:0] TC_ICALL    = 4'd8;
   localparam logic [3:0] TC_DCALL    = 4'd9;
   localparam logic [3:0] TC_SWAP     = 4'd12;
   localparam logic [3:0] TC_RETURN   = 4'd13;
   localparam logic [3:0] TC_OTH_IND  = 4'd14;
   localparam logic [3:0] TC_OTH_DIR  = 4'd15;

   localparam int LINK_A = 1;
   localparam int LINK_B = 5;

endpackage

// File: rtl/trc_link_detect.sv
module trc_link_detect #(
   parameter int REG_W = 5
) (
   input  logic [REG_W-1:0] idx,
   output logic             is_link,
   output logic             is_alt
);
   localparam logic [REG_W-1:0] IDX_A = REG_W'(trc_pkg::LINK_A);
   localparam logic [REG_W-1:0] IDX_B = REG_W'(trc_pkg::LINK_B);

   always_comb begin
      is_alt  = (idx == IDX_B);
      is_link = (idx == IDX_A) || is_alt;
   end
endmodule

// File: rtl/trc_jump_map.sv
module trc_jump_map #(
   parameter bit WIDE_CODE = 1'b1
) (
   input  trc_pkg::op_class_e cls,
   input  logic               rd_link,
   input  logic               rs1_link,
   input  logic               rs1_alt,
   input  logic               same_reg,
   input  logic               all_jumps,
   output logic               is_jump,
   output logic [3:0]         jcode
);
   import trc_pkg::*;

   always_comb begin
      case (cls)
         OPC_JAL, OPC_JALR, OPC_CJAL, OPC_CJ, OPC_CJALR,
         OPC_CJR, OPC_TBLJ, OPC_TBLJAL, OPC_POPRET: is_jump = 1'b1;
         default:                                    is_jump = 1'b0;
      endcase
   end

   if (WIDE_CODE) begin : g_wide
      logic [3:0] dir_plain;
      always_comb begin
         dir_plain = all_jumps ? TC_BR_TK : TC_OTH_DIR;
         case (cls)
            OPC_JAL:    jcode = rd_link ? TC_DCALL : dir_plain;
            OPC_CJAL:   jcode = TC_DCALL;
            OPC_CJ:     jcode = dir_plain;
            OPC_TBLJ:   jcode = dir_plain;
            OPC_TBLJAL: jcode = TC_DCALL;
            OPC_JALR: begin
               if (rd_link && rs1_link)
                  jcode = same_reg ? TC_ICALL : TC_SWAP;
               else if (rd_link)
                  jcode = TC_ICALL;
               else if (rs1_link)
                  jcode = TC_RETURN;
               else
                  jcode = TC_OTH_IND;
            end
            OPC_CJALR:  jcode = rs1_alt ? TC_SWAP : TC_ICALL;
            OPC_CJR:    jcode = rs1_link ? TC_RETURN : TC_OTH_IND;
            OPC_POPRET: jcode = TC_RETURN;
            default:    jcode = TC_NONE;
         endcase
      end
   end else begin : g_narrow
      logic unused_narrow;
      always_comb begin
         unused_narrow = rd_link ^ rs1_link ^ rs1_alt ^ same_reg;
         case (cls)
            OPC_JAL, OPC_CJAL, OPC_CJ, OPC_TBLJ, OPC_TBLJAL:
               jcode = all_jumps ? TC_BR_TK : TC_NONE;
            OPC_JALR, OPC_CJALR, OPC_CJR, OPC_POPRET:
               jcode = TC_IND;
            default:
               jcode = TC_NONE;
         endcase
      end
   end
endmodule

// File: rtl/trc_base_map.sv
module trc_base_map (
   input  trc_pkg::op_class_e cls,
   input  logic               trap_exc,
   input  logic               trap_irq,
   input  logic               br_taken,
   input  logic               is_jump,
   input  logic [3:0]         jcode,
   output logic [3:0]         code
);
   import trc_pkg::*;

   always_comb begin
      if (trap_irq)
         code = TC_IRQ;
      else if (trap_exc)
         code = TC_EXC;
      else if (is_jump)
         code = jcode;
      else begin
         case (cls)
            OPC_ENV:    code = TC_EXC;
            OPC_XRET:   code = TC_TRET;
            OPC_BRANCH: code = br_taken ? TC_BR_TK : TC_BR_NT;
            default:    code = TC_NONE;
         endcase
      end
   end
endmodule

// File: rtl/trc_type_reg.sv
module trc_type_reg #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   output logic [CODE_W-1:0] out_code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_code <= in_code;
      end
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_code));
endmodule

// File: rtl/trc_itype_classifier.sv
module trc_itype_classifier #(
   parameter bit WIDE_CODE = 1'b1,
   parameter int REG_W     = 5,
   localparam int CODE_W   = WIDE_CODE ? 4 : 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_valid,
   input  logic [3:0]        op_class,
   input  logic [REG_W-1:0]  rd_idx,
   input  logic [REG_W-1:0]  rs1_idx,
   input  logic              trap_exc,
   input  logic              trap_irq,
   input  logic              br_taken,
   input  logic              all_jumps_en,
   output logic              type_valid,
   output logic [CODE_W-1:0] type_code
);
   import trc_pkg::*;

   if (REG_W < 3) begin : g_bad_reg_w
      $error("REG_W must be at least 3 to name x5");
   end

   localparam int NREG = 2;

   op_class_e             cls;
   logic [NREG-1:0][REG_W-1:0] reg_idx;
   logic [NREG-1:0]       link_hit;
   logic [NREG-1:0]       alt_hit;
   logic                  jmp_flag;
   logic [3:0]            jmp_code;
   logic [3:0]            full_code;
   logic                  unused_alt;

   assign cls        = op_class_e'(op_class);
   assign reg_idx[0] = rd_idx;
   assign reg_idx[1] = rs1_idx;
   assign unused_alt = alt_hit[0];

   for (genvar g = 0; g < NREG; g++) begin : g_link
      trc_link_detect #(.REG_W(REG_W)) u_link (
         .idx     (reg_idx[g]),
         .is_link (link_hit[g]),
         .is_alt  (alt_hit[g])
      );
   end

   trc_jump_map #(.WIDE_CODE(WIDE_CODE)) u_jmap (
      .cls       (cls),
      .rd_link   (link_hit[0]),
      .rs1_link  (link_hit[1]),
      .rs1_alt   (alt_hit[1]),
      .same_reg  (rd_idx == rs1_idx),
      .all_jumps (all_jumps_en),
      .is_jump   (jmp_flag),
      .jcode     (jmp_code)
   );

   trc_base_map u_bmap (
      .cls      (cls),
      .trap_exc (trap_exc),
      .trap_irq (trap_irq),
      .br_taken (br_taken),
      .is_jump  (jmp_flag),
      .jcode    (jmp_code),
      .code     (full_code)
   );

   logic [CODE_W-1:0] next_code;
   logic              unused_hi;
   if (CODE_W < 4) begin : g_trunc
      assign next_code = full_code[CODE_W-1:0];
      assign unused_hi = full_code[3];
   end else begin : g_full
      assign next_code = full_code;
      assign unused_hi = 1'b0;
   end

   trc_type_reg #(.CODE_W(CODE_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (ret_valid),
      .in_code   (next_code),
      .out_valid (type_valid),
      .out_code  (type_code)
   );

   assert_valid_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> type_valid);
   assert_valid_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_valid |=> !type_valid);
   assert_irq_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && trap_irq |=> type_code == CODE_W'(2));
   assert_exc_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && trap_exc && !trap_irq |=> type_code == CODE_W'(1));

   if (WIDE_CODE) begin : g_wide_chk
      assert_jalr_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ret_valid && !trap_exc && !trap_irq && op_class == 4'd3 &&
         (rs1_idx == REG_W'(1) || rs1_idx == REG_W'(5)) &&
         !(rd_idx == REG_W'(1) || rd_idx == REG_W'(5))
         |=> type_code == CODE_W'(13));
      assert_no_generic_R8: assert property (@(posedge clk) disable iff (!rst_n)
         type_valid |-> type_code != CODE_W'(6));
   end else begin : g_narrow_chk
      assert_narrow_ind_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ret_valid && !trap_exc && !trap_irq && op_class == 4'd3
         |=> type_code == CODE_W'(6));
   end
endmodule

// File: tb/trc_itype_classifier_tb.sv
module trc_itype_classifier_tb;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W = 5;

   localparam logic [3:0] C_OTHER = 4'd0, C_BR = 4'd1, C_JAL = 4'd2, C_JALR = 4'd3,
                          C_CJAL = 4'd4, C_CJ = 4'd5, C_CJALR = 4'd6, C_CJR = 4'd7,
                          C_TBLJ = 4'd8, C_TBLJAL = 4'd9, C_POPRET = 4'd10,
                          C_XRET = 4'd11, C_ENV = 4'd12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ret_valid = 1'b0;
   logic [3:0] op_class = '0;
   logic [REG_W-1:0] rd_idx = '0, rs1_idx = '0;
   logic trap_exc = 1'b0, trap_irq = 1'b0, br_taken = 1'b0, all_jumps_en = 1'b0;
   logic v4, v3;
   logic [3:0] code4;
   logic [2:0] code3;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trc_itype_classifier #(.WIDE_CODE(1'b1), .REG_W(REG_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .op_class(op_class),
      .rd_idx(rd_idx), .rs1_idx(rs1_idx), .trap_exc(trap_exc), .trap_irq(trap_irq),
      .br_taken(br_taken), .all_jumps_en(all_jumps_en),
      .type_valid(v4), .type_code(code4));

   trc_itype_classifier #(.WIDE_CODE(1'b0), .REG_W(REG_W)) u_dut3 (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .op_class(op_class),
      .rd_idx(rd_idx), .rs1_idx(rs1_idx), .trap_exc(trap_exc), .trap_irq(trap_irq),
      .br_taken(br_taken), .all_jumps_en(all_jumps_en),
      .type_valid(v3), .type_code(code3));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] cls, input int rd, input int rs1,
                        input logic exc, input logic irq, input logic tk, input logic aj);
      @(negedge clk);
      ret_valid = 1'b1; op_class = cls; rd_idx = REG_W'(rd); rs1_idx = REG_W'(rs1);
      trap_exc = exc; trap_irq = irq; br_taken = tk; all_jumps_en = aj;
      @(posedge clk);
      #1;
   endtask

   task automatic vec(input string req, input logic [3:0] cls, input int rd, input int rs1,
                      input logic exc, input logic irq, input logic tk, input logic aj,
                      input int exp4, input int exp3);
      drive(cls, rd, rs1, exc, irq, tk, aj);
      check({req, " valid"}, int'(v4 & v3), 1);
      check({req, " code4"}, int'(code4), exp4);
      check({req, " code3"}, int'(code3), exp3);
   endtask

   task automatic t_reset_R1;
      #2;
      check("R1 valid4", int'(v4), 0);
      check("R1 code4", int'(code4), 0);
      check("R1 code3", int'(code3), 0);
      repeat (2) @(posedge clk);
      #1;
      check("R1 still in reset", int'(v3), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_classes_R2;
      vec("R2 class13", 4'd13, 0, 0, 0, 0, 0, 0, 0, 0);
      vec("R2 class15", 4'd15, 1, 5, 0, 0, 1, 1, 0, 0);
   endtask

   task automatic t_traps_R4;
      vec("R4 irq", C_JAL, 1, 0, 0, 1, 0, 0, 2, 2);
      vec("R4 exc", C_JALR, 0, 1, 1, 0, 0, 0, 1, 1);
      vec("R4 irq+exc", C_BR, 0, 0, 1, 1, 1, 0, 2, 2);
      vec("R4 exc over branch", C_BR, 0, 0, 1, 0, 1, 0, 1, 1);
   endtask

   task automatic t_base_R5;
      vec("R5 env", C_ENV, 0, 0, 0, 0, 0, 0, 1, 1);
      vec("R5 xret", C_XRET, 0, 0, 0, 0, 0, 0, 3, 3);
      vec("R5 br taken", C_BR, 0, 0, 0, 0, 1, 0, 5, 5);
      vec("R5 br not taken", C_BR, 0, 0, 0, 0, 0, 0, 4, 4);
      vec("R5 other", C_OTHER, 1, 5, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_link_R6;
      vec("R6 jal x1", C_JAL, 1, 0, 0, 0, 0, 0, 9, 0);
      vec("R6 jal x5", C_JAL, 5, 0, 0, 0, 0, 0, 9, 0);
      vec("R6 jal x2", C_JAL, 2, 0, 0, 0, 0, 0, 15, 0);
      vec("R6 jal x21", C_JAL, 21, 0, 0, 0, 0, 0, 15, 0);
      vec("R6 jalr rs1 x17", C_JALR, 0, 17, 0, 0, 0, 0, 14, 6);
   endtask

   task automatic t_direct_R7;
      vec("R7 jal x0", C_JAL, 0, 0, 0, 0, 0, 0, 15, 0);
      vec("R7 cjal", C_CJAL, 1, 0, 0, 0, 0, 0, 9, 0);
      vec("R7 cj", C_CJ, 0, 0, 0, 0, 0, 0, 15, 0);
      vec("R7 tblj", C_TBLJ, 0, 0, 0, 0, 0, 0, 15, 0);
      vec("R7 tbljal", C_TBLJAL, 1, 0, 0, 0, 0, 0, 9, 0);
   endtask

   task automatic t_jalr_R8;
      vec("R8 call x1<-x6", C_JALR, 1, 6, 0, 0, 0, 0, 8, 6);
      vec("R8 swap x1,x5", C_JALR, 1, 5, 0, 0, 0, 0, 12, 6);
      vec("R8 swap x5,x1", C_JALR, 5, 1, 0, 0, 0, 0, 12, 6);
      vec("R8 call x1,x1", C_JALR, 1, 1, 0, 0, 0, 0, 8, 6);
      vec("R8 call x5,x5", C_JALR, 5, 5, 0, 0, 0, 0, 8, 6);
      vec("R8 ret rs1 x1", C_JALR, 0, 1, 0, 0, 0, 0, 13, 6);
      vec("R8 ret rs1 x5", C_JALR, 0, 5, 0, 0, 0, 0, 13, 6);
      vec("R8 other x0,x6", C_JALR, 0, 6, 0, 0, 0, 0, 14, 6);
      vec("R8 other x3,x7", C_JALR, 3, 7, 0, 0, 0, 0, 14, 6);
   endtask

   task automatic t_compressed_R9;
      vec("R9 cjalr x5", C_CJALR, 1, 5, 0, 0, 0, 0, 12, 6);
      vec("R9 cjalr x1", C_CJALR, 1, 1, 0, 0, 0, 0, 8, 6);
      vec("R9 cjalr x9", C_CJALR, 1, 9, 0, 0, 0, 0, 8, 6);
      vec("R9 cjr x1", C_CJR, 0, 1, 0, 0, 0, 0, 13, 6);
      vec("R9 cjr x5", C_CJR, 0, 5, 0, 0, 0, 0, 13, 6);
      vec("R9 cjr x2", C_CJR, 0, 2, 0, 0, 0, 0, 14, 6);
      vec("R9 popret", C_POPRET, 0, 0, 0, 0, 0, 0, 13, 6);
   endtask

   task automatic t_narrow_R10;
      vec("R10 narrow tbljal", C_TBLJAL, 0, 0, 0, 0, 0, 0, 9, 0);
      vec("R10 narrow popret", C_POPRET, 1, 1, 0, 0, 0, 0, 13, 6);
   endtask

   task automatic t_alljumps_R11;
      vec("R11 jal x2", C_JAL, 2, 0, 0, 0, 0, 1, 5, 5);
      vec("R11 jal x1", C_JAL, 1, 0, 0, 0, 0, 1, 9, 5);
      vec("R11 cj", C_CJ, 0, 0, 0, 0, 0, 1, 5, 5);
      vec("R11 cjal", C_CJAL, 1, 0, 0, 0, 0, 1, 9, 5);
      vec("R11 tblj", C_TBLJ, 0, 0, 0, 0, 0, 1, 5, 5);
      vec("R11 tbljal", C_TBLJAL, 0, 0, 0, 0, 0, 1, 9, 5);
      vec("R11 jalr untouched", C_JALR, 0, 6, 0, 0, 0, 1, 14, 6);
      vec("R11 branch nt untouched", C_BR, 0, 0, 0, 0, 0, 1, 4, 4);
   endtask

   task automatic t_hold_R3;
      vec("R3 load", C_JALR, 0, 1, 0, 0, 0, 0, 13, 6);
      @(negedge clk);
      ret_valid = 1'b0; op_class = C_BR; br_taken = 1'b1; trap_irq = 1'b1;
      @(posedge clk);
      #1;
      check("R3 valid4 low", int'(v4), 0);
      check("R3 valid3 low", int'(v3), 0);
      check("R3 code4 held", int'(code4), 13);
      check("R3 code3 held", int'(code3), 6);
      @(posedge clk);
      #1;
      check("R3 code4 still held", int'(code4), 13);
      trap_irq = 1'b0;
      vec("R3 resume", C_XRET, 0, 0, 0, 0, 0, 0, 3, 3);
   endtask

   initial begin
      t_reset_R1();
      t_classes_R2();
      t_traps_R4();
      t_base_R5();
      t_link_R6();
      t_direct_R7();
      t_jalr_R8();
      t_compressed_R9();
      t_narrow_R10();
      t_alljumps_R11();
      t_hold_R3();
      @(negedge clk);
      ret_valid = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule